// File: doc/BRIEF.md
# Programmable Rate Generator Timer Channel

This block is one channel of a programmable interval timer. Software programs it through two byte-wide write strobes that share a single data byte. The first strobe carries a control word, which picks the channel, the byte-loading pattern and the counting mode. The second strobe carries count bytes. Once a full count has been loaded, the channel divides the input clock by that count. It keeps its output high and drops it for one clock at the end of every period, so a downstream interrupt controller sees a steady periodic tick.

Only the periodic rate-generator mode counts, and only in binary. A control word addressed to another channel is left for that channel to decode. A control word with the latch access code is also not handled here. A new count written while the channel runs takes effect at the next reload, so the period changes without a glitch.

Top module: `pit_channel`

## Requirements
- R1: During and after reset the output `rate_out` is high and no pulse appears until a control word and a full count have been written.
- R2: Control word layout: bits 7:6 select the channel, bits 5:4 the access pattern, bits 3:1 the mode and bit 0 BCD (1) or binary (0). A control word whose channel field differs from `CHAN_ID`, or whose access field is 00, has no effect, and a running channel keeps its period.
- R3: An accepted control word stops counting and forces `rate_out` high from the next cycle. It also resets the byte toggle, so the next data write is taken as a low byte.
- R4: With access field 11, the first data write after the control word is the count's low byte and the second is its high byte. If the high byte is written at clock edge W with count N, `rate_out` is first low in the cycle after edge W+N-1.
- R5: While running, `rate_out` is low for exactly one clock in every N clocks, and the counter reloads the programmed count after each low cycle.
- R6: With access field 01, a single data write loads the low byte, the high byte is taken as zero, and counting starts.
- R7: With access field 10, a single data write loads the high byte, the low byte is taken as zero, and counting starts.
- R8: A loaded count of 0 gives a period of 65536 clocks.
- R9: Only mode codes 010 and 110 with bit 0 clear enable counting. After any other accepted control word, data writes start nothing and `rate_out` stays high.
- R10: A count completed while the channel runs replaces the reload value. The current period finishes unchanged. If the count completes on the same edge as a reload, that reload already uses the new count.
- R11: If both strobes are active in one cycle, only the control word is taken and the data strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Strobe: `wr_byte` is a control word |
| data_wr | input | 1 | Strobe: `wr_byte` is a count byte |
| wr_byte | input | 8 | Shared write data byte |
| rate_out | output | 1 | High normally; low for one clock at each period end |

## Verification
Two functions can fall in the same cycle, and each collision is provoked on purpose.

The first is the completion of a new count (the high-byte write) landing on the reload edge of a running period. The bench times the high-byte write to the edge where the counter sits at 1. It then judges the result by whether the following pulses are spaced at the new count right away.

The second is both write strobes active in one cycle. The bench then loads a short count. A design that wrongly took the data byte would assemble a very different count, and its expected pulse would not appear.

// File: rtl/pit_pkg.sv
// Package: shared encodings for the timer channel.
// Assumes an 8-bit write bus and a count of two bytes.
package pit_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = 2 * BYTE_W;

    // Byte-loading pattern taken from the control word.
    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_LOHI  = 2'b11
    } acc_e;

    // Control word fields, most significant first.
    typedef struct packed {
        logic [1:0] sel;
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_word_t;
endpackage

// File: rtl/pit_ctrl_decode.sv
// Control word decoder: accepts words for this channel and holds the
// access pattern and counting enable. Assumes word and data share a bus.
module pit_ctrl_decode
    import pit_pkg::*;
#(
    parameter int unsigned CHAN_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    output logic              accept_o,
    output acc_e              acc_o,
    output logic              enable_o
);
    localparam logic [1:0] CHAN_SEL = CHAN_ID[1:0];

    ctrl_word_t word;
    acc_e       acc_q;
    logic       en_q;
    logic       mode_ok;

    assign word = ctrl_word_t'(wr_byte_i);

    // Decide whether the word is ours and whether its mode can count.
    always_comb begin
        accept_o = ctrl_wr_i && (word.sel == CHAN_SEL) && (word.acc != ACC_LATCH);
        mode_ok  = ((word.mode == 3'b010) || (word.mode == 3'b110)) && !word.bcd;
    end

    // Hold the programmed access pattern and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= ACC_LOHI;
            en_q  <= 1'b0;
        end else if (accept_o) begin
            acc_q <= word.acc;
            en_q  <= mode_ok;
        end
    end

    assign acc_o    = acc_q;
    assign enable_o = en_q;

    // R2
    foreign_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && word.sel != CHAN_SEL) |=> ($stable(acc_q) && $stable(en_q)));
endmodule

// File: rtl/pit_count_loader.sv
// Count loader: assembles the count from one or two data bytes according
// to the access pattern and flags the cycle in which a count completes.
// Assumes clear_i wins over any data write in the same cycle.
module pit_count_loader
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              enable_i,
    input  acc_e              acc_i,
    input  logic              data_wr_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o
);
    logic              take;
    logic              hi_pending_q;
    logic [BYTE_W-1:0] lo_q;

    assign take = data_wr_i && !clear_i && enable_i;

    // Form the completed count for the current access pattern.
    always_comb begin
        load_o     = 1'b0;
        load_val_o = '0;
        case (acc_i)
            ACC_LO: begin
                load_o     = take;
                load_val_o = {{BYTE_W{1'b0}}, byte_i};
            end
            ACC_HI: begin
                load_o     = take;
                load_val_o = {byte_i, {BYTE_W{1'b0}}};
            end
            ACC_LOHI: begin
                load_o     = take && hi_pending_q;
                load_val_o = {byte_i, lo_q};
            end
            default: begin
                load_o     = 1'b0;
                load_val_o = '0;
            end
        endcase
    end

    // Track the byte toggle and hold the pending low byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_pending_q <= 1'b0;
            lo_q         <= '0;
        end else if (clear_i) begin
            hi_pending_q <= 1'b0;
        end else if (take && acc_i == ACC_LOHI) begin
            hi_pending_q <= !hi_pending_q;
            if (!hi_pending_q) lo_q <= byte_i;
        end
    end

    // R4
    low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr_i && acc_i == ACC_LOHI && !hi_pending_q) |-> !load_o);
endmodule

// File: rtl/pit_rate_counter.sv
// Rate counter: down-counts a loaded value, drops the output for one clock
// when the count is 1, then reloads. A count of 0 wraps to 65536 clocks.
// Assumes stop_i wins over load_i.
module pit_rate_counter
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             out_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             running_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;

    // Count, reload and take in new counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
            reload_q  <= '0;
        end else if (stop_i) begin
            running_q <= 1'b0;
        end else if (load_i && !running_q) begin
            running_q <= 1'b1;
            cnt_q     <= load_val_i;
            reload_q  <= load_val_i;
        end else if (running_q) begin
            if (load_i) reload_q <= load_val_i;
            if (cnt_q == ONE) cnt_q <= load_i ? load_val_i : reload_q;
            else              cnt_q <= cnt_q - ONE;
        end
    end

    // Output is low only in the terminal cycle of a running period.
    assign out_o = !(running_q && cnt_q == ONE);

    // R5
    single_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_o && reload_q != ONE && !stop_i && !load_i) |=> out_o);
    // R10
    reload_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && cnt_q == ONE && load_i && !stop_i) |=> (cnt_q == $past(load_val_i)));
    // R8
    zero_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && cnt_q == '0 && !stop_i) |=> (cnt_q == '1));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_q && !load_i) |=> !running_q);
endmodule

// File: rtl/pit_channel.sv
// Timer channel top: ties the control decoder, count loader and rate
// counter together. Assumes one shared write byte with two strobes.
module pit_channel
    import pit_pkg::*;
#(
    parameter int unsigned CHAN_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic              rate_out
);
    logic             accept;
    acc_e             acc;
    logic             enable;
    logic             load;
    logic [CNT_W-1:0] load_val;

    pit_ctrl_decode #(.CHAN_ID(CHAN_ID)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr_i (ctrl_wr),
        .wr_byte_i (wr_byte),
        .accept_o  (accept),
        .acc_o     (acc),
        .enable_o  (enable)
    );

    pit_count_loader u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (accept),
        .enable_i   (enable),
        .acc_i      (acc),
        .data_wr_i  (data_wr),
        .byte_i     (wr_byte),
        .load_o     (load),
        .load_val_o (load_val)
    );

    pit_rate_counter u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_i     (accept),
        .load_i     (load),
        .load_val_i (load_val),
        .out_o      (rate_out)
    );

    // R3
    stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rate_out);
endmodule

// File: tb/test_pit_channel.sv
// Scoreboard bench: the driver pushes expected pulse cycles, the monitor
// pops and compares them as low pulses appear on rate_out.
module test_pit_channel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       rate_out;

    always #5 clk = ~clk;

    pit_channel #(.CHAN_ID(0)) i_pit_channel (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .data_wr  (data_wr),
        .wr_byte  (wr_byte),
        .rate_out (rate_out)
    );

    typedef struct {
        int    at;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string ctx = "R1";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: compare each low pulse with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sb.size() > 0 && sb[0].at < cyc) begin
                check(1'b0, sb[0].tag, "missing pulse at cycle", -1, sb[0].at);
                void'(sb.pop_front());
            end
            if (rate_out !== 1'b1) begin
                if (sb.size() == 0) begin
                    check(1'b0, ctx, "unexpected low output at cycle", cyc, -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cyc == e.at, e.tag, "pulse cycle", cyc, e.at);
                end
            end
        end
    end

    task automatic put(input logic c, input logic d, input logic [7:0] v);
        ctrl_wr = c;
        data_wr = d;
        wr_byte = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
        data_wr = 1'b0;
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic put_at(input int edge_no, input logic c, input logic d,
                          input logic [7:0] v);
        wait_to(edge_no - 1);
        put(c, d, v);
    endtask

    task automatic expect_train(input int first, input int period, input int n,
                                input string tag);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.at  = first + k * period;
            e.tag = tag;
            sb.push_back(e);
        end
    endtask

    task automatic stop_and_settle(input string tag);
        put(1'b1, 1'b0, 8'h34);
        check(rate_out === 1'b1, tag, "output after stop", rate_out, 1);
        check(sb.size() == 0, tag, "pending expected pulses", sb.size(), 0);
    endtask

    task automatic hold_high(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            check(rate_out === 1'b1, tag, "output held high", rate_out, 1);
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int w;
        // R1: reset state
        repeat (2) @(negedge clk);
        check(rate_out === 1'b1, "R1", "output in reset", rate_out, 1);
        rst_n = 1'b1;
        hold_high(5, "R1");

        // R4 / R5: low then high, N=5
        ctx = "R4";
        put(1'b1, 1'b0, 8'h34);
        put(1'b0, 1'b1, 8'h05);
        hold_high(3, "R4");
        put(1'b0, 1'b1, 8'h00);
        w = cyc;
        expect_train(w + 4, 5, 1, "R4");
        expect_train(w + 9, 5, 3, "R5");
        wait_to(w + 21);
        ctx = "R3";
        stop_and_settle("R3");
        hold_high(20, "R3");
        // R3: toggle reset after a lone low byte
        put(1'b0, 1'b1, 8'h99);
        put(1'b1, 1'b0, 8'h34);
        put(1'b0, 1'b1, 8'h08);
        put(1'b0, 1'b1, 8'h00);
        w = cyc;
        expect_train(w + 7, 8, 2, "R3");
        wait_to(w + 17);
        stop_and_settle("R3");

        // R2: foreign channel and latch words ignored while running
        ctx = "R2";
        put(1'b1, 1'b0, 8'h34);
        put(1'b0, 1'b1, 8'h06);
        put(1'b0, 1'b1, 8'h00);
        w = cyc;
        expect_train(w + 5, 6, 5, "R2");
        put_at(w + 2, 1'b1, 1'b0, 8'h74);
        put(1'b1, 1'b0, 8'h00);
        put(1'b1, 1'b0, 8'hB4);
        wait_to(w + 31);
        stop_and_settle("R2");

        // R6: low byte only, N=7
        ctx = "R6";
        put(1'b1, 1'b0, 8'h14);
        put(1'b0, 1'b1, 8'h07);
        w = cyc;
        expect_train(w + 6, 7, 3, "R6");
        wait_to(w + 22);
        stop_and_settle("R6");

        // R7: high byte only, N=256
        ctx = "R7";
        put(1'b1, 1'b0, 8'h24);
        put(1'b0, 1'b1, 8'h01);
        w = cyc;
        expect_train(w + 255, 256, 2, "R7");
        wait_to(w + 513);
        stop_and_settle("R7");

        // R9: mode code 110 also counts, N=4
        ctx = "R9";
        put(1'b1, 1'b0, 8'h3C);
        put(1'b0, 1'b1, 8'h04);
        put(1'b0, 1'b1, 8'h00);
        w = cyc;
        expect_train(w + 3, 4, 2, "R9");
        wait_to(w + 9);
        stop_and_settle("R9");
        // R9: unsupported mode and BCD start nothing
        put(1'b1, 1'b0, 8'h30);
        put(1'b0, 1'b1, 8'h03);
        put(1'b0, 1'b1, 8'h00);
        hold_high(20, "R9");
        put(1'b1, 1'b0, 8'h35);
        put(1'b0, 1'b1, 8'h03);
        put(1'b0, 1'b1, 8'h00);
        hold_high(20, "R9");

        // R10: new count mid-period applies at next reload
        ctx = "R10";
        put(1'b1, 1'b0, 8'h34);
        put(1'b0, 1'b1, 8'h0A);
        put(1'b0, 1'b1, 8'h00);
        w = cyc;
        expect_train(w + 9, 10, 1, "R10");
        expect_train(w + 12, 3, 2, "R10");
        put_at(w + 3, 1'b0, 1'b1, 8'h03);
        put_at(w + 4, 1'b0, 1'b1, 8'h00);
        wait_to(w + 16);
        stop_and_settle("R10");
        // R10: new count completes on the reload edge
        put(1'b0, 1'b1, 8'h0A);
        put(1'b0, 1'b1, 8'h00);
        w = cyc;
        expect_train(w + 9, 10, 1, "R10");
        expect_train(w + 13, 4, 3, "R10");
        put_at(w + 5, 1'b0, 1'b1, 8'h04);
        put_at(w + 10, 1'b0, 1'b1, 8'h00);
        wait_to(w + 23);
        stop_and_settle("R10");

        // R11: both strobes in one cycle, control wins
        ctx = "R11";
        put(1'b0, 1'b1, 8'h05);
        put(1'b0, 1'b1, 8'h00);
        w = cyc;
        put_at(w + 2, 1'b1, 1'b1, 8'h34);
        hold_high(10, "R11");
        put(1'b0, 1'b1, 8'h06);
        put(1'b0, 1'b1, 8'h00);
        w = cyc;
        expect_train(w + 5, 6, 2, "R11");
        wait_to(w + 13);
        stop_and_settle("R11");

        // R8: count 0 means 65536
        ctx = "R8";
        put(1'b0, 1'b1, 8'h00);
        put(1'b0, 1'b1, 8'h00);
        w = cyc;
        expect_train(w + 65535, 65536, 1, "R8");
        wait_to(w + 65537);
        stop_and_settle("R8");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule